// File: doc/BRIEF.md
# Multi-Host Command Register Lock

This block is the host side of a command port that two or more CPUs share. It holds a command register and an extension register. Each register answers at two addresses: a plain alias and a locking alias. A lock flag reserves the port for one host. The flag is never written directly. It changes as a side effect of which alias a host reads or writes, and only while no command is running. A busy flag covers each accepted command. A command written while busy is dropped, and a sticky overrun bit records the loss. The execution engine itself lies outside the block. It is represented by a minimum busy time and a `exec_done` input.

The execution state machine has three states. `EX_IDLE` goes to `EX_RUN` when a command is accepted. `EX_RUN` goes to `EX_IDLE` on `exec_done` once the minimum time has passed. `EX_RUN` goes to `EX_HOLD` on an early `exec_done`. `EX_HOLD` goes to `EX_IDLE` when the minimum time is reached.

The lock state machine has two states. `LK_FREE` goes to `LK_HELD` on an acquire event: a read of the locking command alias, or a write to either locking alias. `LK_HELD` goes to `LK_FREE` on a release event, which is a write to the plain command alias. Neither transition is taken while busy is 1.

Top module: `cmd_lock_port`

## Requirements
- R1: After reset, busy and locked are 0, no issue strobe is asserted, the overrun bit is 0, and reads of every alias return zero.
- R2: A command write is accepted when busy is 0. Address 0 is the plain command alias and address 1 is the locking command alias. On the next cycle issue_valid is 1 for exactly one cycle. issue_cmd carries the written low DW-3 bits. issue_ext carries the extension word held before the write. From that cycle busy is 1.
- R3: Busy stays 1 for at least MIN_BUSY cycles and until exec_done has been seen. It drops on the cycle after the later of the two. exec_done is ignored while busy is 0.
- R4: A read of address 1 while busy is 0 sets locked to 1. The read data carries the busy and lock bits as they stood before the access, so the acquiring host sees lock 0.
- R5: A write to address 0 while busy is 0 issues the command and clears locked to 0.
- R6: A write to address 1, or to address 3 (the locking extension alias), while busy is 0 leaves locked at 1.
- R7: Reads of address 0, 2 or 3 and writes to address 2 (the plain extension alias) leave locked unchanged.
- R8: While busy is 1, no access to any address changes locked. This includes a read of address 1 while both busy and lock are 1.
- R9: A command write while busy is 1 is ignored. No strobe is issued and the command field keeps its value. The overrun bit is set.
- R10: A read of address 0 or 1 returns the overrun bit as it stood and then clears it.
- R11: Command read word layout: bit DW-1 is busy, bit DW-2 is lock, bit DW-3 is overrun, and bits DW-4..0 are the last accepted command. Reads of address 2 or 3 return the extension word. A write to address 2 or 3 updates the extension word at any time. acc_rdata is zero when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | 0 cmd, 1 cmd locking, 2 ext, 3 ext locking |
| acc_wdata | input | DW | Write data |
| acc_rdata | output | DW | Read data in the same cycle, zero when no read |
| exec_done | input | 1 | Engine finished the current command |
| issue_valid | output | 1 | One-cycle command issue strobe |
| issue_cmd | output | DW-3 | Issued command word |
| issue_ext | output | DW | Extension word issued with it |
| busy | output | 1 | Command executing |
| locked | output | 1 | Lock flag |

## Verification
The assertions watch several behaviours on every cycle:
- the lock flag stays frozen while busy;
- an acquire, a release or a locking write gives the right next lock value;
- the issue strobe lasts a single cycle and only appears while busy is set;
- a rejected write raises overrun and issues nothing;
- busy cannot drop before the minimum time or without done.

Some behaviours need the bench's scenarios and its reference model:
- the pre-access values returned by an acquiring read;
- the exact cycle busy falls after an early and after a late done;
- the extension word that travels with a command;
- the overrun bit surviving until a read.

// File: rtl/cmdl_pkg.sv
package cmdl_pkg;

    typedef enum logic [1:0] {
        AD_CMD    = 2'd0,
        AD_CMD_LK = 2'd1,
        AD_EXT    = 2'd2,
        AD_EXT_LK = 2'd3
    } cmdl_addr_e;

    typedef struct packed {
        logic rd_cmd;
        logic rd_cmd_lk;
        logic wr_cmd;
        logic wr_cmd_lk;
        logic rd_ext;
        logic wr_ext;
        logic wr_ext_lk;
    } cmdl_evt_t;

    typedef enum logic {
        LK_FREE,
        LK_HELD
    } cmdl_lock_e;

    typedef enum logic [1:0] {
        EX_IDLE,
        EX_RUN,
        EX_HOLD
    } cmdl_exec_e;

endpackage

// File: rtl/cmdl_decode.sv
module cmdl_decode
    import cmdl_pkg::*;
(
    input  logic       valid,
    input  logic       write,
    input  logic [1:0] addr,
    output cmdl_evt_t  evt
);

    cmdl_addr_e addr_e;

    assign addr_e = cmdl_addr_e'(addr);

    always_comb begin
        evt = '0;
        if (valid) begin
            unique case (addr_e)
                AD_CMD: begin
                    if (write) evt.wr_cmd = 1'b1;
                    else       evt.rd_cmd = 1'b1;
                end
                AD_CMD_LK: begin
                    if (write) begin
                        evt.wr_cmd    = 1'b1;
                        evt.wr_cmd_lk = 1'b1;
                    end else begin
                        evt.rd_cmd    = 1'b1;
                        evt.rd_cmd_lk = 1'b1;
                    end
                end
                AD_EXT: begin
                    if (write) evt.wr_ext = 1'b1;
                    else       evt.rd_ext = 1'b1;
                end
                AD_EXT_LK: begin
                    if (write) begin
                        evt.wr_ext    = 1'b1;
                        evt.wr_ext_lk = 1'b1;
                    end else begin
                        evt.rd_ext    = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cmdl_lock_fsm.sv
module cmdl_lock_fsm
    import cmdl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      busy,
    input  cmdl_evt_t evt,
    output logic      locked
);

    cmdl_lock_e state_q;
    cmdl_lock_e state_d;
    logic       grab;
    logic       drop;

    assign grab = evt.rd_cmd_lk | evt.wr_cmd_lk | evt.wr_ext_lk;
    assign drop = evt.wr_cmd & ~evt.wr_cmd_lk;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!busy) begin
            unique case (state_q)
                LK_FREE: if (grab) state_d = LK_HELD;
                LK_HELD: if (drop) state_d = LK_FREE;
                default: state_d = LK_FREE;
            endcase
        end
    end

    always_comb begin
        locked = (state_q == LK_HELD);
    end

    p_frozen_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(locked));

    p_acquire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && evt.rd_cmd_lk) |=> locked);

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && evt.wr_cmd && !evt.wr_cmd_lk) |=> !locked);

    p_lock_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (evt.wr_cmd_lk || evt.wr_ext_lk)) |=> locked);

    p_neutral_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !evt.wr_cmd && !evt.rd_cmd_lk && !evt.wr_ext_lk) |=> $stable(locked));

endmodule

// File: rtl/cmdl_exec_fsm.sv
module cmdl_exec_fsm
    import cmdl_pkg::*;
#(
    parameter int MIN_BUSY = 72
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    output logic busy
);

    localparam int CNT_W = (MIN_BUSY > 1) ? $clog2(MIN_BUSY) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_BUSY - 1);

    cmdl_exec_e       state_q;
    cmdl_exec_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             min_met;

    assign min_met = (cnt_q >= CNT_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (start)              cnt_q <= '0;
        else if (busy && !min_met)   cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EX_IDLE: if (start) state_d = EX_RUN;
            EX_RUN: begin
                if (done && min_met) state_d = EX_IDLE;
                else if (done)       state_d = EX_HOLD;
            end
            EX_HOLD: if (min_met) state_d = EX_IDLE;
            default: state_d = EX_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q != EX_IDLE);
    end

    p_min_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !min_met) |=> busy);

    p_wait_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EX_RUN && !done) |=> busy);

    p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/cmd_lock_port.sv
module cmd_lock_port
    import cmdl_pkg::*;
#(
    parameter int DW       = 32,
    parameter int MIN_BUSY = 72
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic [1:0]      acc_addr,
    input  logic [DW-1:0]   acc_wdata,
    output logic [DW-1:0]   acc_rdata,
    input  logic            exec_done,
    output logic            issue_valid,
    output logic [DW-4:0]   issue_cmd,
    output logic [DW-1:0]   issue_ext,
    output logic            busy,
    output logic            locked
);

    localparam int CMD_W = DW - 3;

    cmdl_evt_t        evt;
    logic             accept;
    logic             reject;
    logic [CMD_W-1:0] cmd_q;
    logic [DW-1:0]    ext_q;
    logic             ovr_q;

    cmdl_decode u_decode (
        .valid (acc_valid),
        .write (acc_write),
        .addr  (acc_addr),
        .evt   (evt)
    );

    cmdl_exec_fsm #(.MIN_BUSY(MIN_BUSY)) u_exec (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .done  (exec_done),
        .busy  (busy)
    );

    cmdl_lock_fsm u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (busy),
        .evt    (evt),
        .locked (locked)
    );

    assign accept = evt.wr_cmd & ~busy;
    assign reject = evt.wr_cmd &  busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q       <= '0;
            ext_q       <= '0;
            ovr_q       <= 1'b0;
            issue_valid <= 1'b0;
            issue_cmd   <= '0;
            issue_ext   <= '0;
        end else begin
            issue_valid <= accept;
            if (accept) begin
                cmd_q     <= acc_wdata[CMD_W-1:0];
                issue_cmd <= acc_wdata[CMD_W-1:0];
                issue_ext <= ext_q;
            end
            if (evt.wr_ext) ext_q <= acc_wdata;
            if (reject)          ovr_q <= 1'b1;
            else if (evt.rd_cmd) ovr_q <= 1'b0;
        end
    end

    always_comb begin
        acc_rdata = '0;
        if (evt.rd_cmd)      acc_rdata = {busy, locked, ovr_q, cmd_q};
        else if (evt.rd_ext) acc_rdata = ext_q;
    end

    p_issue_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !issue_valid);

    p_issue_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> busy);

    p_reject_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (ovr_q && !issue_valid));

    p_reject_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> $stable(cmd_q));

    p_ovr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt.rd_cmd |=> !ovr_q);

    p_ext_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt.wr_ext |=> (ext_q == $past(acc_wdata)));

    p_evt_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> ($countones({evt.rd_cmd, evt.wr_cmd, evt.rd_ext, evt.wr_ext}) == 1));

endmodule

// File: tb/test_cmd_lock_port.sv
`timescale 1ns/1ps
module test_cmd_lock_port;

    localparam int DW    = 32;
    localparam int MINB  = 72;
    localparam int CMD_W = DW - 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            acc_valid, acc_write, exec_done;
    logic [1:0]      acc_addr;
    logic [DW-1:0]   acc_wdata, acc_rdata, issue_ext;
    logic [CMD_W-1:0] issue_cmd;
    logic            issue_valid, busy, locked;

    int checks = 0;
    int errors = 0;

    bit               m_busy, m_lock, m_ovr, m_issue, m_seen;
    int               m_cnt;
    logic [CMD_W-1:0] m_cmd, m_icmd;
    logic [DW-1:0]    m_ext, m_iext;

    always #2 clk = ~clk;

    cmd_lock_port #(.DW(DW), .MIN_BUSY(MINB)) i_cmd_lock_port (
        .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid), .acc_write (acc_write),
        .acc_addr (acc_addr), .acc_wdata (acc_wdata), .acc_rdata (acc_rdata),
        .exec_done (exec_done), .issue_valid (issue_valid), .issue_cmd (issue_cmd),
        .issue_ext (issue_ext), .busy (busy), .locked (locked)
    );

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic w, input logic [1:0] a,
                        input logic [DW-1:0] d, input logic dn, input string tag);
        logic [DW-1:0] exp_rd;
        bit ob;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d; exec_done = dn;
        #1;
        exp_rd = '0;
        if (v && !w) exp_rd = (a < 2) ? {m_busy, m_lock, m_ovr, m_cmd} : m_ext;
        chk(tag, "rdata", acc_rdata, exp_rd);
        chk(tag, "busy", {31'b0, busy}, {31'b0, m_busy});
        chk(tag, "locked", {31'b0, locked}, {31'b0, m_lock});
        chk(tag, "issue_valid", {31'b0, issue_valid}, {31'b0, m_issue});
        if (m_issue) begin
            chk(tag, "issue_cmd", {3'b0, issue_cmd}, {3'b0, m_icmd});
            chk(tag, "issue_ext", issue_ext, m_iext);
        end
        @(posedge clk);
        ob = m_busy;
        m_issue = 1'b0;
        if (ob) begin
            if ((dn || m_seen) && m_cnt >= MINB - 1) m_busy = 1'b0;
            else begin
                if (dn) m_seen = 1'b1;
                m_cnt++;
            end
        end
        if (v && w && a < 2) begin
            if (ob) m_ovr = 1'b1;
            else begin
                m_issue = 1'b1; m_icmd = d[CMD_W-1:0]; m_iext = m_ext;
                m_cmd = d[CMD_W-1:0]; m_busy = 1'b1; m_cnt = 0; m_seen = 1'b0;
            end
        end
        if (v && w && a >= 2) m_ext = d;
        if (v && !w && a < 2) m_ovr = 1'b0;
        if (!ob) begin
            if (v && !w && a == 1) m_lock = 1'b1;
            if (v && w && a == 0) m_lock = 1'b0;
            if (v && w && (a == 1 || a == 3)) m_lock = 1'b1;
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, '0, 1'b0, tag);
    endtask

    task automatic drain(input int done_at, input string tag);
        for (int i = 0; i < 400 && m_busy; i++)
            step(1'b0, 1'b0, 2'd0, '0, (i == done_at), tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R3 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; acc_valid = 0; acc_write = 0; acc_addr = 0; acc_wdata = 0; exec_done = 0;
        m_busy = 0; m_lock = 0; m_ovr = 0; m_issue = 0; m_seen = 0; m_cnt = 0;
        m_cmd = '0; m_icmd = '0; m_ext = '0; m_iext = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state on every alias
        idle(2, "R1");
        for (int a = 0; a < 4; a++) step(1'b1, 1'b0, 2'(a), '0, 1'b0, "R1");
        // R11, R7: extension writes and neutral reads
        step(1'b1, 1'b1, 2'd2, 32'hCAFE_0001, 1'b0, "R11");
        step(1'b1, 1'b0, 2'd3, '0, 1'b0, "R7");
        step(1'b1, 1'b0, 2'd0, '0, 1'b0, "R7");
        // R3: done while idle ignored
        step(1'b0, 1'b0, 2'd0, '0, 1'b1, "R3");
        // R4: acquire via locking read, then re-read
        step(1'b1, 1'b0, 2'd1, '0, 1'b0, "R4");
        step(1'b1, 1'b0, 2'd1, '0, 1'b0, "R4");
        // R2, R6: locking command write
        step(1'b1, 1'b1, 2'd1, 32'h0123_4567, 1'b0, "R2");
        step(1'b1, 1'b0, 2'd1, '0, 1'b0, "R8");
        step(1'b1, 1'b1, 2'd0, 32'h0BAD_0BAD, 1'b0, "R9");
        step(1'b1, 1'b1, 2'd3, 32'h0000_5A5A, 1'b0, "R8");
        // R3: early done, busy held to minimum
        drain(5, "R3");
        // R10: overrun read then cleared
        step(1'b1, 1'b0, 2'd0, '0, 1'b0, "R10");
        step(1'b1, 1'b0, 2'd1, '0, 1'b0, "R10");
        // R5: plain write releases, late done
        step(1'b1, 1'b1, 2'd0, 32'h1555_AAAA, 1'b0, "R5");
        drain(100, "R3");
        // R6: locking extension write; R7 neutral accesses
        step(1'b1, 1'b1, 2'd3, 32'h7777_0000, 1'b0, "R6");
        step(1'b1, 1'b1, 2'd2, 32'h8888_1111, 1'b0, "R7");
        step(1'b1, 1'b0, 2'd2, '0, 1'b0, "R7");
        step(1'b1, 1'b0, 2'd0, '0, 1'b0, "R7");
        // R2: extension travels with plain command, exact minimum with done at boundary
        step(1'b1, 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0, "R2");
        drain(MINB - 1, "R3");
        idle(3, "R1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule